// File: doc/BRIEF.md
# Parallel ADC Host Interface Controller

This block sits on the host side of a parallel-bus analog-to-digital converter and drives its chip select, write strobe and read strobe. It also watches the converter's active-low interrupt line. A small command port tells it to load the converter's two control words, to start a conversion stream, or to stop that stream. Each conversion appears on a result port together with a single-cycle valid pulse.

A configuration command performs two bus writes: control word zero first, then control word one. Each write selects the converter, drives the data bus, pulses the write strobe and releases the converter again. A start command then selects the converter and keeps it selected for the whole stream. Each read strobe falling edge sets the sample instant and starts a conversion. The controller holds the strobe low until the interrupt reports that the result is ready, captures the bus, and then raises the strobe to end the cycle. If the interrupt never arrives, a timeout with a programmable limit aborts the stream and raises a sticky error flag.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, chip select, write strobe and read strobe are high, the bus driver is off, and result valid, busy and the timeout flag are low.
- R2: A configuration command (cmd_op = 1) accepted while idle produces two bus writes, carrying cfg_word0 and then cfg_word1. Each write has four phases: one cycle with chip select low, bus driven and write strobe high; write strobe low for 1 + WAIT_STATES cycles; one cycle with write strobe high, chip select still low and the bus still driven; and one cycle with chip select high. The whole command occupies 2·(WAIT_STATES + 4) busy cycles.
- R3: A start command (cmd_op = 2) accepted while idle drives chip select low in the next cycle, with read strobe still high. Read strobe falls one cycle later. Chip select then stays low across every read cycle until the stream ends.
- R4: Read strobe stays low for at least 1 + WAIT_STATES cycles. The result is captured at the first clock edge at which the strobe has been low for that long and the interrupt is low. Read strobe rises in the cycle after that edge.
- R5: res_data equals the bus value at the capture edge. res_valid is high for exactly the one cycle in which read strobe is first high again.
- R6: After a capture, read strobe stays high for 1 + WAIT_STATES cycles and then falls again to start the next conversion.
- R7: A stop command (cmd_op = 3) given during a read cycle takes effect only when that cycle ends. After the strobe-high phase, chip select rises instead of a new strobe fall. A stop given in the last high cycle still ends the stream at that point.
- R8: If the interrupt is still high when the read-strobe-low cycle index reaches timeout_lim (counting from 0), read strobe and chip select rise in the next cycle and timeout_err becomes 1. A capture that becomes possible at that same index wins over the timeout. timeout_err stays set until the next accepted start command.
- R9: Commands other than stop have no effect while busy; for example, a configuration command during a stream produces no write strobe. busy is high in every cycle that is not idle.
- R10: A stop command while idle has no effect: chip select stays high and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 none, 1 configure, 2 start stream, 3 stop stream |
| cfg_word0 | input | DATA_W | First control word, written first |
| cfg_word1 | input | DATA_W | Second control word |
| timeout_lim | input | TMO_W | Last read-low cycle index allowed before timeout |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_rd_n | output | 1 | Read strobe / conversion start, active low |
| adc_int_n | input | 1 | Conversion-done interrupt, active low |
| adc_bus_out | output | DATA_W | Data driven toward the converter |
| adc_bus_oe | output | 1 | Bus driver enable |
| adc_bus_in | input | DATA_W | Data returned by the converter |
| res_data | output | DATA_W | Last captured conversion |
| res_valid | output | 1 | One-cycle pulse with a new result |
| busy | output | 1 | Controller not idle |
| timeout_err | output | 1 | Sticky interrupt timeout flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the interrupt arriving and the timeout expiring: the bench raises the interrupt exactly at read-low index timeout_lim. It expects a capture, with a read-low phase of timeout_lim + 1 cycles, the right data and no error flag. The second pair is a stop command and the end of the read-high phase: the bench issues the stop in the final high cycle. It expects chip select to rise in the following cycle, with no further read strobe fall.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_CONFIG = 2'd1,
    OP_START  = 2'd2,
    OP_STOP   = 2'd3
  } host_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WSTROBE,
    ST_WHOLD,
    ST_WGAP,
    ST_RSETUP,
    ST_RLOW,
    ST_RHIGH
  } host_st_e;

  // A strobe phase lasting 1 + ws cycles ends when the phase count reaches ws.
  function automatic logic strobe_done(input logic [31:0] cnt, input logic [31:0] ws);
    return cnt >= ws;
  endfunction

  // The result may be taken once the minimum low time is met and the interrupt is low.
  function automatic logic read_ready(input logic [31:0] cnt, input logic [31:0] ws,
                                      input logic int_n);
    return (cnt >= ws) && !int_n;
  endfunction

  function automatic logic wait_expired(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/adc_host_cnt.sv
module adc_host_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] q
);
  // Saturating count of cycles since the last clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (clr)      q <= '0;
    else if (q != '1)  q <= q + 1'b1;
  end
endmodule

// File: rtl/adc_host_capture.sv
module adc_host_capture #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] data,
  output logic         valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= take;
      if (take) data <= bus_in;
    end
  end

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int WAIT_STATES = 1,
  parameter int TMO_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cfg_word0,
  input  logic [DATA_W-1:0] cfg_word1,
  input  logic [TMO_W-1:0]  timeout_lim,
  output logic              adc_cs_n,
  output logic              adc_wr_n,
  output logic              adc_rd_n,
  input  logic              adc_int_n,
  output logic [DATA_W-1:0] adc_bus_out,
  output logic              adc_bus_oe,
  input  logic [DATA_W-1:0] adc_bus_in,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  output logic              busy,
  output logic              timeout_err
);
  localparam int SW = $clog2(WAIT_STATES + 2);
  localparam int CW = (TMO_W > SW) ? TMO_W : SW;
  localparam logic [31:0] WS32 = 32'(WAIT_STATES);

  host_st_e          st, st_n;
  host_op_e          op;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] cfg0_q, cfg1_q;
  logic              sel_q, stop_pend;

  // Named internal events
  logic cmd_cfg, cmd_start, cmd_stop;
  logic capture_evt, timeout_evt, cycle_end, stream_on;

  assign op        = host_op_e'(cmd_op);
  assign cmd_cfg   = cmd_valid && (op == OP_CONFIG) && (st == ST_IDLE);
  assign cmd_start = cmd_valid && (op == OP_START)  && (st == ST_IDLE);
  assign cmd_stop  = cmd_valid && (op == OP_STOP);
  assign stream_on = st inside {ST_RSETUP, ST_RLOW, ST_RHIGH};

  assign capture_evt = (st == ST_RLOW) && read_ready(32'(cnt), WS32, adc_int_n);
  assign timeout_evt = (st == ST_RLOW) && !capture_evt &&
                       wait_expired(32'(cnt), 32'(timeout_lim));
  assign cycle_end   = (st == ST_RHIGH) && strobe_done(32'(cnt), WS32);

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:    if (cmd_cfg) st_n = ST_WSETUP;
                  else if (cmd_start) st_n = ST_RSETUP;
      ST_WSETUP:  st_n = ST_WSTROBE;
      ST_WSTROBE: if (strobe_done(32'(cnt), WS32)) st_n = ST_WHOLD;
      ST_WHOLD:   st_n = ST_WGAP;
      ST_WGAP:    st_n = sel_q ? ST_IDLE : ST_WSETUP;
      ST_RSETUP:  st_n = ST_RLOW;
      ST_RLOW:    if (capture_evt) st_n = ST_RHIGH;
                  else if (timeout_evt) st_n = ST_IDLE;
      ST_RHIGH:   if (cycle_end) st_n = (stop_pend || cmd_stop) ? ST_IDLE : ST_RLOW;
      default:    st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cfg0_q      <= '0;
      cfg1_q      <= '0;
      sel_q       <= 1'b0;
      stop_pend   <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      st <= st_n;
      if (cmd_cfg) begin
        cfg0_q <= cfg_word0;
        cfg1_q <= cfg_word1;
        sel_q  <= 1'b0;
      end else if (st == ST_WGAP) begin
        sel_q <= 1'b1;
      end
      if (st_n == ST_IDLE)           stop_pend <= 1'b0;
      else if (cmd_stop && stream_on) stop_pend <= 1'b1;
      if (cmd_start)        timeout_err <= 1'b0;
      else if (timeout_evt) timeout_err <= 1'b1;
    end
  end

  adc_host_cnt #(.W(CW)) u_phase_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_n != st),
    .q     (cnt)
  );

  adc_host_capture #(.W(DATA_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (capture_evt),
    .bus_in (adc_bus_in),
    .data   (res_data),
    .valid  (res_valid)
  );

  assign busy        = (st != ST_IDLE);
  assign adc_cs_n    = !(st inside {ST_WSETUP, ST_WSTROBE, ST_WHOLD, ST_RSETUP, ST_RLOW, ST_RHIGH});
  assign adc_wr_n    = (st != ST_WSTROBE);
  assign adc_rd_n    = (st != ST_RLOW);
  assign adc_bus_oe  = st inside {ST_WSETUP, ST_WSTROBE, ST_WHOLD};
  assign adc_bus_out = sel_q ? cfg1_q : cfg0_q;

  // Assertions next to the bus logic
  int wr_low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wr_low_len <= 0;
    else if (!adc_wr_n) wr_low_len <= wr_low_len + 1;
    else                wr_low_len <= 0;
  end

  assert_wr_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_wr_n) |-> (wr_low_len == WAIT_STATES + 1));

  assert_wr_release_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_wr_n) |-> (!adc_cs_n && adc_bus_oe));

  assert_rd_under_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rd_n) |-> ($past(!adc_cs_n) && !adc_cs_n));

  assert_capture_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(!adc_int_n) && $past(!adc_rd_n) && adc_rd_n));

  assert_timeout_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (adc_rd_n && adc_cs_n && $past(adc_int_n)));
endmodule

// File: tb/adc_host_ctrl_test.sv
`timescale 1ns/1ps
module adc_host_ctrl_test;
  localparam int DW  = 8;
  localparam int WS  = 2;
  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [DW-1:0] cfg0 = 8'h4E, cfg1 = 8'hB2;
  logic [15:0] tlim = 16'(LIM);
  logic cs_n, wr_n, rd_n, int_n, oe, rv, busy, terr;
  logic [DW-1:0] bus_out, bus_in, rdata;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int wr_falls = 0;
  logic wr_prev = 1'b1;

  always #4 clk = ~clk;

  adc_host_ctrl #(.DATA_W(DW), .WAIT_STATES(WS), .TMO_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cfg_word0(cfg0), .cfg_word1(cfg1), .timeout_lim(tlim),
    .adc_cs_n(cs_n), .adc_wr_n(wr_n), .adc_rd_n(rd_n), .adc_int_n(int_n),
    .adc_bus_out(bus_out), .adc_bus_oe(oe), .adc_bus_in(bus_in),
    .res_data(rdata), .res_valid(rv), .busy(busy), .timeout_err(terr));

  // Counts write strobe falls seen at the pins
  always @(negedge clk) begin
    if (wr_prev && !wr_n) wr_falls++;
    wr_prev <= wr_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Read-low phase; entered at the negedge of the first low cycle.
  task automatic conv(input int d, input logic [DW-1:0] val, input int inj_at,
                      input logic [1:0] inj_op, output int low_len);
    low_len = 0;
    cmd_op = inj_op;
    while (1) begin
      if (low_len == d) begin int_n = 1'b0; bus_in = val; end
      cmd_valid = (low_len == inj_at);
      @(negedge clk);
      low_len++;
      if (rd_n || low_len > 100) break;
    end
    cmd_valid = 1'b0;
    int_n = 1'b1;
    bus_in = '0;
  endtask

  // Read-high phase; entered at the negedge of the first high cycle.
  task automatic high_phase(input int inj_at, input logic [1:0] inj_op,
                            output int hi_len, output bit ended);
    hi_len = 1;
    cmd_op = inj_op;
    while (1) begin
      cmd_valid = (hi_len - 1 == inj_at);
      @(negedge clk);
      if (!rd_n || cs_n || hi_len > 100) break;
      hi_len++;
    end
    cmd_valid = 1'b0;
    ended = cs_n;
  endtask

  task automatic pulse_cmd(input logic [1:0] op);
    cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // {int delay, value, expected low length, injected op}
  localparam logic [25:0] VEC [0:4] = '{
    {8'd0, 8'hA5, 8'd3, 2'd0},
    {8'd2, 8'h3C, 8'd3, 2'd0},
    {8'd4, 8'hFF, 8'd5, 2'd1},   // config during stream must be ignored
    {8'd1, 8'h00, 8'd3, 2'd0},
    {8'd6, 8'h81, 8'd7, 2'd0}    // interrupt at the timeout index
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int_n = 1'b1; bus_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(cs_n && wr_n && rd_n, "R1 strobes high", {cs_n, wr_n, rd_n}, 7);
    chk(!oe && !rv && !busy && !terr, "R1 flags low", {oe, rv, busy, terr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 configuration writes
    begin
      int cyc = 0, nf = 0, lowlen = 0;
      logic pw = 1'b1;
      pulse_cmd(2'd1);
      while (busy && cyc < 60) begin
        cyc++;
        if (pw && !wr_n) begin
          chk(bus_out == (nf == 0 ? cfg0 : cfg1) && oe && !cs_n, "R2 write data",
              bus_out, nf == 0 ? cfg0 : cfg1);
          nf++; lowlen = 0;
        end
        if (!wr_n) lowlen++;
        if (!pw && wr_n) begin
          chk(lowlen == WS + 1, "R2 strobe length", lowlen, WS + 1);
          chk(!cs_n && oe, "R2 hold after strobe", {cs_n, oe}, 1);
        end
        pw = wr_n;
        @(negedge clk);
      end
      chk(nf == 2, "R2 write count", nf, 2);
      chk(cyc == 2 * (WS + 4), "R2 busy cycles", cyc, 2 * (WS + 4));
      chk(cs_n && !busy, "R2 idle after", {cs_n, busy}, 2);
    end

    // R10 stop while idle
    pulse_cmd(2'd3);
    chk(cs_n && !busy, "R10 stop in idle", {cs_n, busy}, 2);

    // R3 start
    pulse_cmd(2'd2);
    chk(!cs_n && rd_n, "R3 select before strobe", {cs_n, rd_n}, 1);
    @(negedge clk);
    chk(!rd_n && !cs_n, "R3 strobe falls", {cs_n, rd_n}, 0);

    // Vector table walk
    for (int i = 0; i < 5; i++) begin
      int d = int'(VEC[i][25:18]);
      logic [DW-1:0] v = VEC[i][17:10];
      int el = int'(VEC[i][9:2]);
      int wf, ll, hl;
      bit en;
      wf = wr_falls;
      conv(d, v, 0, VEC[i][1:0], ll);
      chk(ll == el, "R4 low length", ll, el);
      chk(rv && rdata == v, "R5 result", rdata, v);
      chk(!terr, "R8 capture wins", terr, 0);
      high_phase(-1, 2'd0, hl, en);
      chk(!rv || hl > 1, "R5 single pulse", rv, 0);
      chk(hl == WS + 1 && !en, "R6 high length", hl, WS + 1);
      chk(!cs_n, "R3 select held", cs_n, 0);
      if (VEC[i][1:0] == 2'd1) chk(wr_falls == wf, "R9 config ignored", wr_falls, wf);
    end

    // R7 stop during low phase
    begin
      int ll, hl; bit en;
      conv(1, 8'h5A, 0, 2'd3, ll);
      chk(rv && rdata == 8'h5A, "R7 cycle completes", rdata, 8'h5A);
      high_phase(-1, 2'd0, hl, en);
      chk(en && hl == WS + 1, "R7 stop after high phase", hl, WS + 1);
      @(negedge clk);
      chk(!busy && rd_n, "R7 idle", busy, 0);
    end

    // R8 timeout
    begin
      int ll;
      pulse_cmd(2'd2);
      @(negedge clk);
      conv(50, 8'h77, -1, 2'd0, ll);
      chk(ll == LIM + 1, "R8 timeout length", ll, LIM + 1);
      chk(terr && cs_n && !rv && !busy, "R8 abort", {terr, cs_n, rv, busy}, 4'b1100);
      @(negedge clk);
      chk(terr, "R8 sticky", terr, 1);
      pulse_cmd(2'd2);
      chk(!terr && !cs_n, "R8 cleared by start", terr, 0);
      @(negedge clk);
    end

    // R7 stop in the last high cycle
    begin
      int ll, hl; bit en;
      conv(0, 8'h11, -1, 2'd0, ll);
      chk(rv && rdata == 8'h11, "R5 after restart", rdata, 8'h11);
      high_phase(WS, 2'd3, hl, en);
      chk(en && hl == WS + 1, "R7 stop at cycle end", hl, WS + 1);
    end

    summary();
  end
endmodule